// File: doc/BRIEF.md
# Registered Raster Sync Generator

This block produces the timing skeleton of a 640x480 raster from a pixel clock and a pixel-enable strobe. Two wrapping counters track the position in the frame. The horizontal counter steps once per enabled clock. The vertical counter steps once per completed line. The counters stay inside the block. The outputs are horizontal and vertical sync, a horizontal-active flag, a vertical-active flag, a combined video enable and a blanking flag. A downstream pixel pipeline uses these to fetch data and to force black outside the picture.

The visible picture sits at count zero of both counters, followed by front porch, sync and back porch. Each output is a flip-flop that a single equality match sets and a second equality match clears, so the output path has no magnitude comparator and no gate. The match constants are taken one count early, so each output is already valid for the position the counters hold after the same enabled edge. Vertical edges happen only on the enabled edge that ends a line. Porch and sync lengths and the level of each sync pulse are parameters. There is no state machine: the only sequencing is the two counters and the set/clear flags.

Top module: `raster_sync_gen`

## Requirements
- R1: The horizontal position runs 0 to H_ACTIVE+H_FRONT+H_SYNC+H_BACK-1 and wraps to 0. The vertical position runs 0 to V_ACTIVE+V_FRONT+V_SYNC+V_BACK-1 and advances only when a line wraps, so one frame takes exactly H_TOTAL*V_TOTAL enabled clocks. Defaults are 800 and 525.
- R2: A clock with `pix_en` low changes neither the position nor any output.
- R3: After an enabled edge that leaves the horizontal position at h, `hsync` is at its asserted level exactly when H_ACTIVE+H_FRONT <= h < H_ACTIVE+H_FRONT+H_SYNC.
- R4: `vsync` is asserted exactly on lines v with V_ACTIVE+V_FRONT <= v < V_ACTIVE+V_FRONT+V_SYNC. It changes only on the enabled edge that moves the horizontal position from its last count to 0.
- R5: A sync whose polarity parameter is 1 is asserted as 0 and idles at 1. A parameter of 0 gives the opposite. Both default to 1.
- R6: `h_active` is 1 exactly for h < H_ACTIVE. `v_active` is 1 exactly for v < V_ACTIVE.
- R7: `vid_en` is 1 exactly when `h_active` and `v_active` are both 1, valid in the same cycle.
- R8: `blank` is always the inverse of `vid_en` in the same cycle.
- R9: A clock with `rst` high sets both positions to 0. It drives both syncs to their idle level, `h_active`, `v_active` and `vid_en` to 0, and `blank` to 1.
- R10: Because the active flags are set only at a wrap, after reset `h_active` stays 0 until the first line wrap, and `v_active` stays 0 until the first frame wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Advances the raster position on this clock when high |
| hsync | output | 1 | Registered horizontal sync at the configured level |
| vsync | output | 1 | Registered vertical sync at the configured level |
| h_active | output | 1 | High across the visible pixels of a line |
| v_active | output | 1 | High across the visible lines of a frame |
| vid_en | output | 1 | High inside the visible picture |
| blank | output | 1 | High outside the visible picture |

## Verification
Every output is due on the same enabled edge that moves the hidden position. After n enabled clocks since reset, the outputs must describe position n modulo the frame. The bench counts enabled edges itself and samples all outputs at the following falling edge, so each comparison lands one register after the stimulus that caused it. Vertical results follow the same rule, with their edges appearing only where the position crosses from a line's last count to 0. Clocks with the enable low must show the previous sample again.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    // index of each set/clear flag in the flag bank
    typedef enum int {
        FLG_HSYNC = 0,
        FLG_VSYNC = 1,
        FLG_HACT  = 2,
        FLG_VACT  = 3
    } flag_idx_e;

    localparam int NUM_FLAGS = 4;

    function automatic int cnt_width(input int total);
        return (total <= 2) ? 1 : $clog2(total);
    endfunction

endpackage

// File: rtl/rsg_wrap_counter.sv
module rsg_wrap_counter #(
    parameter int TOTAL = 800,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    localparam logic [W-1:0] LAST_C = W'(TOTAL - 1);

    assign at_last = (cnt == LAST_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (adv) begin
            if (at_last) cnt <= '0;
            else         cnt <= cnt + 1'b1;
        end
    end

    a_r1_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_C);
    a_r1_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (adv && at_last) |=> (cnt == '0));
    a_r2_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));

endmodule

// File: rtl/rsg_edge_flag.sv
module rsg_edge_flag #(
    parameter bit ACT_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic set_hit,
    input  logic clr_hit,
    output logic lvl_q,
    output logic asserted_nxt
);
    logic lvl_d;

    always_comb begin
        lvl_d = lvl_q;
        if (step) begin
            if (set_hit)      lvl_d = ACT_LEVEL;
            else if (clr_hit) lvl_d = ~ACT_LEVEL;
        end
    end

    assign asserted_nxt = (lvl_d == ACT_LEVEL);

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= ~ACT_LEVEL;
        else     lvl_q <= lvl_d;
    end

    a_r2_flag_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(lvl_q));

endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BACK   = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 10,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 33,
    parameter bit HSYNC_ACTIVE_LOW = 1'b1,
    parameter bit VSYNC_ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pix_en,
    output logic hsync,
    output logic vsync,
    output logic h_active,
    output logic v_active,
    output logic vid_en,
    output logic blank
);
    import rsg_pkg::*;

    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int HW = cnt_width(H_TOTAL);
    localparam int VW = cnt_width(V_TOTAL);

    // match constants one count early: outputs are registered
    localparam logic [HW-1:0] HS_SET_C  = HW'(H_ACTIVE + H_FRONT - 1);
    localparam logic [HW-1:0] HS_CLR_C  = HW'(H_ACTIVE + H_FRONT + H_SYNC - 1);
    localparam logic [HW-1:0] HA_CLR_C  = HW'(H_ACTIVE - 1);
    localparam logic [VW-1:0] VS_SET_C  = VW'(V_ACTIVE + V_FRONT - 1);
    localparam logic [VW-1:0] VS_CLR_C  = VW'(V_ACTIVE + V_FRONT + V_SYNC - 1);
    localparam logic [VW-1:0] VA_CLR_C  = VW'(V_ACTIVE - 1);

    localparam logic [NUM_FLAGS-1:0] ACT_LVL =
        {1'b1, 1'b1, ~VSYNC_ACTIVE_LOW, ~HSYNC_ACTIVE_LOW};

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          h_last;
    logic          v_last;
    logic          line_step;

    assign line_step = pix_en && h_last;

    rsg_wrap_counter #(.TOTAL(H_TOTAL), .W(HW)) u_hcnt (
        .clk(clk), .rst(rst), .adv(pix_en), .cnt(hcnt), .at_last(h_last)
    );

    rsg_wrap_counter #(.TOTAL(V_TOTAL), .W(VW)) u_vcnt (
        .clk(clk), .rst(rst), .adv(line_step), .cnt(vcnt), .at_last(v_last)
    );

    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [NUM_FLAGS-1:0] lvl_v;
    logic [NUM_FLAGS-1:0] nxt_v;

    always_comb begin
        set_v[FLG_HSYNC] = (hcnt == HS_SET_C);
        clr_v[FLG_HSYNC] = (hcnt == HS_CLR_C);
        set_v[FLG_VSYNC] = h_last && (vcnt == VS_SET_C);
        clr_v[FLG_VSYNC] = h_last && (vcnt == VS_CLR_C);
        set_v[FLG_HACT]  = h_last;
        clr_v[FLG_HACT]  = (hcnt == HA_CLR_C);
        set_v[FLG_VACT]  = h_last && v_last;
        clr_v[FLG_VACT]  = h_last && (vcnt == VA_CLR_C);
    end

    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        rsg_edge_flag #(.ACT_LEVEL(ACT_LVL[gi])) u_flag (
            .clk(clk), .rst(rst), .step(pix_en),
            .set_hit(set_v[gi]), .clr_hit(clr_v[gi]),
            .lvl_q(lvl_v[gi]), .asserted_nxt(nxt_v[gi])
        );
    end

    assign hsync    = lvl_v[FLG_HSYNC];
    assign vsync    = lvl_v[FLG_VSYNC];
    assign h_active = lvl_v[FLG_HACT];
    assign v_active = lvl_v[FLG_VACT];

    // combined enable built from the flags' next state, so it lines up with them
    always_ff @(posedge clk) begin
        if (rst) begin
            vid_en <= 1'b0;
            blank  <= 1'b1;
        end else begin
            vid_en <= nxt_v[FLG_HACT] && nxt_v[FLG_VACT];
            blank  <= !(nxt_v[FLG_HACT] && nxt_v[FLG_VACT]);
        end
    end

    a_r2_out_hold: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> ($stable(vid_en) && $stable(hsync) && $stable(vsync)));
    a_r4_vsync_line_edge: assert property (@(posedge clk) disable iff (rst)
        (!$stable(vsync) && !$past(rst)) |-> $past(h_last && pix_en));
    a_r7_en_needs_flags: assert property (@(posedge clk) disable iff (rst)
        vid_en |-> (h_active && v_active));
    a_r7_flags_give_en: assert property (@(posedge clk) disable iff (rst)
        (h_active && v_active) |-> vid_en);
    a_r8_blank_inverse: assert property (@(posedge clk) disable iff (rst)
        blank != vid_en);

endmodule

// File: tb/raster_sync_gen_test.sv
`timescale 1ns/1ps
module raster_sync_gen_test;

    // small configuration: 15 counts per line, 8 lines per frame
    localparam int SHA = 8, SHF = 2, SHS = 3, SHB = 2;
    localparam int SVA = 4, SVF = 1, SVS = 2, SVB = 1;
    localparam int SHT = SHA + SHF + SHS + SHB;
    localparam int FHT = 800;

    logic clk = 1'b0;
    logic rst;
    logic pix_en;
    always #4 clk = ~clk;

    logic s_hs, s_vs, s_ha, s_va, s_en, s_bl;
    logic p_hs, p_vs, p_ha, p_va, p_en, p_bl;
    logic f_hs, f_vs, f_ha, f_va, f_en, f_bl;

    raster_sync_gen #(.H_ACTIVE(SHA), .H_FRONT(SHF), .H_SYNC(SHS), .H_BACK(SHB),
                      .V_ACTIVE(SVA), .V_FRONT(SVF), .V_SYNC(SVS), .V_BACK(SVB)) uut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .hsync(s_hs), .vsync(s_vs),
        .h_active(s_ha), .v_active(s_va), .vid_en(s_en), .blank(s_bl));

    raster_sync_gen #(.H_ACTIVE(SHA), .H_FRONT(SHF), .H_SYNC(SHS), .H_BACK(SHB),
                      .V_ACTIVE(SVA), .V_FRONT(SVF), .V_SYNC(SVS), .V_BACK(SVB),
                      .HSYNC_ACTIVE_LOW(1'b0), .VSYNC_ACTIVE_LOW(1'b0)) uut_pos (
        .clk(clk), .rst(rst), .pix_en(pix_en), .hsync(p_hs), .vsync(p_vs),
        .h_active(p_ha), .v_active(p_va), .vid_en(p_en), .blank(p_bl));

    raster_sync_gen uut_full (
        .clk(clk), .rst(rst), .pix_en(pix_en), .hsync(f_hs), .vsync(f_vs),
        .h_active(f_ha), .v_active(f_va), .vid_en(f_en), .blank(f_bl));

    int n_checks = 0;
    int n_fail   = 0;
    int n_step   = 0;
    bit done     = 0;
    bit prev_en  = 0;
    logic [5:0] prev_s;

    // expected {hs, vs, ha, va, en, bl} as asserted (positive) levels
    function automatic logic [5:0] expect_vec(input int n, input int ha, input int hf,
            input int hs, input int hb, input int va, input int vf, input int vs, input int vb);
        int ht = ha + hf + hs + hb;
        int vt = va + vf + vs + vb;
        int p  = n % (ht * vt);
        int h  = p % ht;
        int v  = p / ht;
        logic e_hs = (h >= ha + hf) && (h < ha + hf + hs);
        logic e_vs = (v >= va + vf) && (v < va + vf + vs);
        logic e_ha = (h < ha) && (n >= ht);
        logic e_va = (v < va) && (n >= ht * vt);
        return {e_hs, e_vs, e_ha, e_va, e_ha && e_va, !(e_ha && e_va)};
    endfunction

    task automatic chk(input string tag, input string sig, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s step=%0d actual=%b expected=%b", tag, sig, n_step, act, exp);
        end
    endtask

    task automatic sample();
        logic [5:0] es = expect_vec(n_step, SHA, SHF, SHS, SHB, SVA, SVF, SVS, SVB);
        logic [5:0] ef = expect_vec(n_step, 640, 16, 96, 48, 480, 10, 2, 33);
        int hpos = n_step % SHT;
        string t_h = rst ? "R9" : "R3";
        string t_v = rst ? "R9" : "R4";
        string t_a = rst ? "R9" : ((n_step < SHT) ? "R10" : ((hpos == 0) ? "R1" : "R6"));
        string t_e = rst ? "R9" : "R7";
        string t_b = rst ? "R9" : "R8";
        chk(t_h, "hsync",    s_hs, !es[5]);
        chk(t_v, "vsync",    s_vs, !es[4]);
        chk(t_a, "h_active", s_ha, es[3]);
        chk(t_a, "v_active", s_va, es[2]);
        chk(t_e, "vid_en",   s_en, es[1]);
        chk(t_b, "blank",    s_bl, es[0]);
        chk("R5", "pos hsync", p_hs, es[5]);
        chk("R5", "pos vsync", p_vs, es[4]);
        chk("R7", "pos vid_en", p_en, es[1]);
        chk("R5", "full hsync", f_hs, !ef[5]);
        chk("R4", "full vsync", f_vs, !ef[4]);
        chk((n_step < FHT) ? "R10" : "R6", "full h_active", f_ha, ef[3]);
        chk("R8", "full blank", f_bl, ef[0]);
        if (!prev_en && !rst)
            chk("R2", "hold", ({s_hs, s_vs, s_ha, s_va, s_en, s_bl} == prev_s), 1'b1);
        prev_s = {s_hs, s_vs, s_ha, s_va, s_en, s_bl};
    endtask

    task automatic tick(input logic en, input logic r);
        pix_en = en;
        rst    = r;
        @(posedge clk);
        if (r) n_step = 0;
        else if (en) n_step++;
        prev_en = en;
        @(negedge clk);
        sample();
    endtask

    initial begin
        rst = 1'b1;
        pix_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        sample();                              // R9 reset state
        for (int c = 0; c < 330; c++) tick((c % 3) != 2, 1'b0);
        for (int c = 0; c < 8; c++)   tick(1'b0, 1'b0);   // R2 long pause
        for (int c = 0; c < 2; c++)   tick(1'b1, 1'b1);   // R9 reset mid-run
        for (int c = 0; c < 2600; c++) tick(1'b1, 1'b0);
        for (int c = 0; c < 60; c++)  tick((c % 5) == 0, 1'b0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired step=%0d actual=hung expected=done", n_step);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule